// File: doc/BRIEF.md
# ACK Airtime Duration Table Generator

This block fills a rate-to-duration table with the on-air time, in microseconds, of an acknowledgement frame. It walks the twelve 2.4 GHz data-rate indices in turn. For each index it picks the rate at which the ACK would be returned, computes how long a 10-byte ACK takes at that rate under the current channel bandwidth, and writes the result into the table. For data rates that can use a short preamble, it writes a second entry. One start pulse runs a whole pass. The block then pulses `done_o` for one cycle.

The airtime is SIFS plus preamble plus a whole number of OFDM symbols. The symbol count is a ceiling division of the payload bit count, times ten, by the product of the ACK bit rate (in units of 100 kb/s) and the symbol time. A repeated-subtraction divider computes it serially, one symbol per clock. Bandwidth mode, ACK-rate policy and the short-preamble capability mask are captured when the pass starts, and they hold until it ends.

Top module: `ackdur_table_gen`

## Requirements
- R1: After reset, and until a start pulse arrives, `tbl_we_o` and `done_o` stay low.
- R2: When `hi_ack_i`=1, the ACK rate index for data index 0..11 is 0,1,1,1,4,4,6,6,8,8,8,8. Rate index n has bit rate 10,20,55,110,60,90,120,180,240,360,480,540 (×100 kb/s) for n = 0..11.
- R3: When `hi_ack_i`=0, data indices 0..3 use ACK index 0 (1 Mb/s) and indices 4..11 use ACK index 4 (6 Mb/s).
- R4: The long entry is SIFS + PRE + SYM×ceil(((22 + 8×10)×10)/(rate×SYM)). With `bw_mode_i`=2'b00 (standard), SIFS=10, PRE=20 and SYM=4. For example, a 1 Mb/s ACK gives 134 µs.
- R5: `bw_mode_i`=2'b10 (half) doubles PRE and SYM and uses SIFS=32. `bw_mode_i`=2'b11 (quarter) quadruples them and uses SIFS=64.
- R6: `bw_mode_i`=2'b01 (turbo) uses SIFS=8, PRE=14 and an unscaled SYM=4.
- R7: If `short_cap_i[i]`=1, the cycle after index i's long entry carries a write with `tbl_short_o`=1, the same index, and data equal to the long value minus 96, floored at 0. If the bit is 0, no short entry is written for that index.
- R8: Long entries are written once each, for indices 0 to 11 in ascending order. A pass makes 12 + popcount(`short_cap_i`) writes, and every long write has `tbl_short_o`=0.
- R9: `done_o` is high for exactly one cycle, in the cycle right after the pass's last write, and no write occurs in that cycle.
- R10: A start pulse that arrives during a pass is ignored. Changes to `bw_mode_i`, `hi_ack_i` or `short_cap_i` during a pass do not affect the values written.
- R11: Every ceiling division completes within 64 cycles of being launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begins a pass when idle |
| bw_mode_i | input | 2 | 00 standard, 01 turbo, 10 half, 11 quarter |
| hi_ack_i | input | 1 | 1: ACK rate follows the data rate; 0: base rates only |
| short_cap_i | input | 12 | Per data index: short-preamble capable |
| tbl_we_o | output | 1 | Table write strobe |
| tbl_idx_o | output | 4 | Data-rate index being written |
| tbl_short_o | output | 1 | Entry is the short-preamble variant |
| tbl_dur_o | output | 16 | Duration in microseconds |
| done_o | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The bench uses the default parameters: a 10-byte frame, 22 PLCP overhead bits, a 64-cycle divide limit and 16-bit durations. With these values the slowest division (a 1 Mb/s ACK in standard or turbo mode) needs 26 subtractions. The quarter-mode 24 Mb/s case finishes on its first compare. Both ends of the divider's iteration range are therefore exercised. Because short entries subtract a fixed 96 µs from OFDM-based airtimes, many of them reach the zero floor. Quarter-mode entries stay above it, so both sides of the floor are checked.

// File: rtl/ackdur_pkg.sv
// Package: shared types and rate lookups for the ACK duration generator.
// Assumes the twelve-entry 2.4 GHz rate ordering (four CCK then eight OFDM).
package ackdur_pkg;

    localparam int RATE_COUNT = 12;
    localparam int IDX_W      = $clog2(RATE_COUNT);

    typedef enum logic [1:0] {
        BW_STD     = 2'b00,
        BW_TURBO   = 2'b01,
        BW_HALF    = 2'b10,
        BW_QUARTER = 2'b11
    } bw_mode_e;

    // Bit rate of a rate index in units of 100 kb/s.
    function automatic logic [9:0] rate_100k(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd0:    return 10'd10;
            4'd1:    return 10'd20;
            4'd2:    return 10'd55;
            4'd3:    return 10'd110;
            4'd4:    return 10'd60;
            4'd5:    return 10'd90;
            4'd6:    return 10'd120;
            4'd7:    return 10'd180;
            4'd8:    return 10'd240;
            4'd9:    return 10'd360;
            4'd10:   return 10'd480;
            4'd11:   return 10'd540;
            default: return 10'd0;
        endcase
    endfunction

    // Rate index used for the ACK answering a given data rate index.
    function automatic logic [IDX_W-1:0] ack_index(input logic [IDX_W-1:0] idx,
                                                    input logic hi);
        if (!hi)
            return (idx < 4'd4) ? 4'd0 : 4'd4;
        if (idx == 4'd0) return 4'd0;
        if (idx < 4'd4)  return 4'd1;
        if (idx < 4'd6)  return 4'd4;
        if (idx < 4'd8)  return 4'd6;
        return 4'd8;
    endfunction

endpackage

// File: rtl/ackdur_rate_pick.sv
// Module: ackdur_rate_pick
// Combinational choice of the ACK bit rate for one data rate index.
// Assumes idx < RATE_COUNT; larger values yield a zero rate.
module ackdur_rate_pick
    import ackdur_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  logic             hi_i,
    output logic [9:0]       rate_o
);

    // Map data index to ACK index, then to its bit rate.
    always_comb begin
        rate_o = rate_100k(ack_index(idx_i, hi_i));
    end

endmodule

// File: rtl/ackdur_bw_timing.sv
// Module: ackdur_bw_timing
// Yields SIFS, preamble time and symbol time for a bandwidth mode.
// Assumes all scaled constants fit in T_W bits.
module ackdur_bw_timing
    import ackdur_pkg::*;
#(
    parameter int T_W          = 8,
    parameter int SIFS_STD     = 10,
    parameter int SIFS_TURBO   = 8,
    parameter int SIFS_HALF    = 32,
    parameter int SIFS_QUARTER = 64,
    parameter int PRE_STD      = 20,
    parameter int PRE_TURBO    = 14,
    parameter int SYM_STD      = 4
) (
    input  logic [1:0]     mode_i,
    output logic [T_W-1:0] sifs_o,
    output logic [T_W-1:0] pre_o,
    output logic [T_W-1:0] sym_o
);

    // Select the timing triple for the latched mode.
    always_comb begin
        case (bw_mode_e'(mode_i))
            BW_TURBO: begin
                sifs_o = T_W'(SIFS_TURBO);
                pre_o  = T_W'(PRE_TURBO);
                sym_o  = T_W'(SYM_STD);
            end
            BW_HALF: begin
                sifs_o = T_W'(SIFS_HALF);
                pre_o  = T_W'(PRE_STD * 2);
                sym_o  = T_W'(SYM_STD * 2);
            end
            BW_QUARTER: begin
                sifs_o = T_W'(SIFS_QUARTER);
                pre_o  = T_W'(PRE_STD * 4);
                sym_o  = T_W'(SYM_STD * 4);
            end
            default: begin
                sifs_o = T_W'(SIFS_STD);
                pre_o  = T_W'(PRE_STD);
                sym_o  = T_W'(SYM_STD);
            end
        endcase
    end

endmodule

// File: rtl/ackdur_ceil_div.sv
// Module: ackdur_ceil_div
// Serial ceiling divider by repeated subtraction, one quotient step per cycle.
// Assumes den_i is nonzero when go_i is high and the quotient stays below LIMIT.
module ackdur_ceil_div #(
    parameter int NUM_W = 14,
    parameter int QW    = 7,
    parameter int LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [NUM_W-1:0] den_i,
    output logic             done_o,
    output logic [QW-1:0]    quot_o
);

    logic [NUM_W-1:0] rem_r;
    logic [NUM_W-1:0] den_r;
    logic             busy_r;
    logic [QW-1:0]    cyc_r;

    // Subtract the divisor until the remainder is used up; count each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r  <= '0;
            den_r  <= '0;
            busy_r <= 1'b0;
            quot_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i) begin
                rem_r  <= num_i;
                den_r  <= den_i;
                quot_o <= '0;
                busy_r <= 1'b1;
            end else if (busy_r) begin
                if (rem_r > den_r) begin
                    rem_r  <= rem_r - den_r;
                    quot_o <= quot_o + 1'b1;
                end else begin
                    rem_r  <= '0;
                    if (rem_r != '0)
                        quot_o <= quot_o + 1'b1;
                    busy_r <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

    // Cycles spent on the current division, for the bound check.
    always_ff @(posedge clk) begin
        if (!rst_n || go_i)
            cyc_r <= '0;
        else if (busy_r && cyc_r != {QW{1'b1}})
            cyc_r <= cyc_r + 1'b1;
    end

    assert_div_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_r |-> (cyc_r < QW'(LIMIT)));

    assert_div_nonzero_den_R11: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (den_i != '0));

endmodule

// File: rtl/ackdur_table_gen.sv
// Module: ackdur_table_gen (top)
// Sequences through all rate indices, computes the ACK airtime for each
// and emits long and short-preamble table writes, then pulses done.
// Assumes the table accepts one write per cycle with no back-pressure.
module ackdur_table_gen
    import ackdur_pkg::*;
#(
    parameter int DUR_W        = 16,
    parameter int FRAME_BYTES  = 10,
    parameter int PLCP_BITS    = 22,
    parameter int SHORT_SAVE   = 96,
    parameter int SIFS_STD     = 10,
    parameter int SIFS_TURBO   = 8,
    parameter int SIFS_HALF    = 32,
    parameter int SIFS_QUARTER = 64,
    parameter int PRE_STD      = 20,
    parameter int PRE_TURBO    = 14,
    parameter int SYM_STD      = 4,
    parameter int DIV_LIMIT    = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [1:0]            bw_mode_i,
    input  logic                  hi_ack_i,
    input  logic [RATE_COUNT-1:0] short_cap_i,
    output logic                  tbl_we_o,
    output logic [IDX_W-1:0]      tbl_idx_o,
    output logic                  tbl_short_o,
    output logic [DUR_W-1:0]      tbl_dur_o,
    output logic                  done_o
);

    localparam int NUMERATOR = (PLCP_BITS + 8 * FRAME_BYTES) * 10;
    localparam int DEN_MAX   = 540 * SYM_STD * 4;
    localparam int NUM_W     = $clog2((NUMERATOR > DEN_MAX ? NUMERATOR : DEN_MAX) + 1);
    localparam int QW        = $clog2(DIV_LIMIT + 1);
    localparam int T_W       = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_DIV, ST_LONG, ST_SHORT, ST_FIN
    } state_e;

    state_e                state_r;
    logic [IDX_W-1:0]      idx_r;
    logic [1:0]            mode_r;
    logic                  hi_r;
    logic [RATE_COUNT-1:0] cap_r;
    logic [DUR_W-1:0]      dur_r;

    logic [9:0]            ack_rate;
    logic [T_W-1:0]        sifs, pre, sym;
    logic                  div_go, div_done;
    logic [QW-1:0]         quot;
    logic [NUM_W-1:0]      den;
    logic [DUR_W-1:0]      dur_next;
    logic [DUR_W-1:0]      short_dur;
    logic                  last_idx;

    ackdur_rate_pick u_rate (
        .idx_i  (idx_r),
        .hi_i   (hi_r),
        .rate_o (ack_rate)
    );

    ackdur_bw_timing #(
        .T_W          (T_W),
        .SIFS_STD     (SIFS_STD),
        .SIFS_TURBO   (SIFS_TURBO),
        .SIFS_HALF    (SIFS_HALF),
        .SIFS_QUARTER (SIFS_QUARTER),
        .PRE_STD      (PRE_STD),
        .PRE_TURBO    (PRE_TURBO),
        .SYM_STD      (SYM_STD)
    ) u_timing (
        .mode_i (mode_r),
        .sifs_o (sifs),
        .pre_o  (pre),
        .sym_o  (sym)
    );

    ackdur_ceil_div #(
        .NUM_W (NUM_W),
        .QW    (QW),
        .LIMIT (DIV_LIMIT)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (div_go),
        .num_i  (NUM_W'(NUMERATOR)),
        .den_i  (den),
        .done_o (div_done),
        .quot_o (quot)
    );

    // Divisor, airtime assembly and short-preamble variant.
    always_comb begin
        den       = NUM_W'(ack_rate) * NUM_W'(sym);
        dur_next  = DUR_W'(sifs) + DUR_W'(pre) + DUR_W'(sym) * DUR_W'(quot);
        short_dur = (dur_r > DUR_W'(SHORT_SAVE)) ? dur_r - DUR_W'(SHORT_SAVE) : '0;
        last_idx  = (idx_r == IDX_W'(RATE_COUNT - 1));
        div_go    = (state_r == ST_LOAD);
    end

    // Pass sequencer: latch configuration, divide, write, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r <= ST_IDLE;
            idx_r   <= '0;
            mode_r  <= 2'b00;
            hi_r    <= 1'b0;
            cap_r   <= '0;
            dur_r   <= '0;
        end else begin
            case (state_r)
                ST_IDLE: if (start_i) begin
                    mode_r  <= bw_mode_i;
                    hi_r    <= hi_ack_i;
                    cap_r   <= short_cap_i;
                    idx_r   <= '0;
                    state_r <= ST_LOAD;
                end
                ST_LOAD: state_r <= ST_DIV;
                ST_DIV: if (div_done) begin
                    dur_r   <= dur_next;
                    state_r <= ST_LONG;
                end
                ST_LONG: begin
                    if (cap_r[idx_r])
                        state_r <= ST_SHORT;
                    else if (last_idx)
                        state_r <= ST_FIN;
                    else begin
                        idx_r   <= idx_r + 1'b1;
                        state_r <= ST_LOAD;
                    end
                end
                ST_SHORT: begin
                    if (last_idx)
                        state_r <= ST_FIN;
                    else begin
                        idx_r   <= idx_r + 1'b1;
                        state_r <= ST_LOAD;
                    end
                end
                default: state_r <= ST_IDLE;
            endcase
        end
    end

    // Table write port and completion pulse.
    always_comb begin
        tbl_we_o    = (state_r == ST_LONG) || (state_r == ST_SHORT);
        tbl_short_o = (state_r == ST_SHORT);
        tbl_idx_o   = idx_r;
        tbl_dur_o   = (state_r == ST_SHORT) ? short_dur : dur_r;
        done_o      = (state_r == ST_FIN);
    end

    assert_short_follows_long_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we_o && tbl_short_o) |->
            ($past(tbl_we_o) && !$past(tbl_short_o) && $past(tbl_idx_o) == tbl_idx_o));

    assert_short_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we_o && tbl_short_o) |->
            (($past(tbl_dur_o) > DUR_W'(SHORT_SAVE)) ?
                (tbl_dur_o == $past(tbl_dur_o) - DUR_W'(SHORT_SAVE)) : (tbl_dur_o == '0)));

    assert_short_only_capable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we_o && tbl_short_o) |-> cap_r[tbl_idx_o]);

    assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we_o |-> (tbl_idx_o < IDX_W'(RATE_COUNT)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!tbl_we_o && $past(tbl_we_o) &&
                    $past(tbl_idx_o) == IDX_W'(RATE_COUNT - 1)));

    assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r != ST_IDLE && $past(state_r) != ST_IDLE) |->
            ($stable(mode_r) && $stable(hi_r) && $stable(cap_r)));

endmodule

// File: tb/tb_ackdur_table_gen.sv
`timescale 1ns/1ps
module tb_ackdur_table_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  bw_mode_i = 2'b00;
    logic        hi_ack_i = 1'b0;
    logic [11:0] short_cap_i = '0;
    logic        tbl_we_o;
    logic [3:0]  tbl_idx_o;
    logic        tbl_short_o;
    logic [15:0] tbl_dur_o;
    logic        done_o;

    ackdur_table_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .bw_mode_i   (bw_mode_i),
        .hi_ack_i    (hi_ack_i),
        .short_cap_i (short_cap_i),
        .tbl_we_o    (tbl_we_o),
        .tbl_idx_o   (tbl_idx_o),
        .tbl_short_o (tbl_short_o),
        .tbl_dur_o   (tbl_dur_o),
        .done_o      (done_o)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int   long_val [12];
    int   short_val[12];
    bit   short_seen[12];
    int   ord_idx[40];
    bit   ord_sh[40];
    int   wr_cnt;
    int   done_cnt;
    int   done_bad;
    bit   prev_we;

    // Observe the write port and done pulse between clock edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tbl_we_o) begin
                if (wr_cnt < 40) begin
                    ord_idx[wr_cnt] = int'(tbl_idx_o);
                    ord_sh[wr_cnt]  = tbl_short_o;
                end
                if (tbl_idx_o < 4'd12) begin
                    if (tbl_short_o) begin
                        short_val[tbl_idx_o]  = int'(tbl_dur_o);
                        short_seen[tbl_idx_o] = 1'b1;
                    end else
                        long_val[tbl_idx_o] = int'(tbl_dur_o);
                end
                wr_cnt++;
            end
            if (done_o) begin
                done_cnt++;
                if (tbl_we_o || !prev_we) done_bad++;
            end
            prev_we = tbl_we_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ack_rate(input int idx, input bit hi);
        int tab[12] = '{10, 20, 20, 20, 60, 60, 120, 120, 240, 240, 240, 240};
        if (hi) return tab[idx];
        return (idx < 4) ? 10 : 60;
    endfunction

    function automatic int exp_long(input int mode, input int idx, input bit hi);
        int sifs, pre, sym, den, q;
        case (mode)
            1: begin sifs = 8;  pre = 14; sym = 4;  end
            2: begin sifs = 32; pre = 40; sym = 8;  end
            3: begin sifs = 64; pre = 80; sym = 16; end
            default: begin sifs = 10; pre = 20; sym = 4; end
        endcase
        den = ack_rate(idx, hi) * sym;
        q = ((22 + 80) * 10 + den - 1) / den;
        return sifs + pre + sym * q;
    endfunction

    task automatic clear_log();
        for (int i = 0; i < 12; i++) begin
            long_val[i] = -1; short_val[i] = -1; short_seen[i] = 0;
        end
        wr_cnt = 0; done_cnt = 0; done_bad = 0;
    endtask

    task automatic pulse_start(input int mode, input bit hi, input logic [11:0] cap);
        @(negedge clk);
        bw_mode_i = 2'(mode); hi_ack_i = hi; short_cap_i = cap; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int n = 0; n < 3000 && done_cnt == 0; n++) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic verify(input int mode, input bit hi, input logic [11:0] cap,
                          input string req);
        int k = 0;
        for (int i = 0; i < 12; i++) begin
            int e = exp_long(mode, i, hi);
            chk(long_val[i] == e, req, long_val[i], e);
            if (cap[i]) begin
                int es = (e > 96) ? e - 96 : 0;
                chk(short_seen[i] && short_val[i] == es, "R7 short value", short_val[i], es);
            end else
                chk(!short_seen[i], "R7 no short entry", int'(short_seen[i]), 0);
        end
        for (int i = 0; i < 12; i++) begin
            chk(ord_idx[k] == i && !ord_sh[k], "R8 long order", ord_idx[k], i);
            k++;
            if (cap[i]) begin
                chk(ord_idx[k] == i && ord_sh[k], "R7 short placement", ord_idx[k], i);
                k++;
            end
        end
        chk(wr_cnt == k, "R8 write count", wr_cnt, k);
        chk(done_cnt == 1, "R9 done pulses", done_cnt, 1);
        chk(done_bad == 0, "R9 done timing", done_bad, 0);
    endtask

    task automatic run_pass(input int mode, input bit hi, input logic [11:0] cap,
                            input string req);
        clear_log();
        pulse_start(mode, hi, cap);
        wait_done();
        verify(mode, hi, cap, req);
    endtask

    task automatic test_reset_r1();
        clear_log();
        repeat (20) @(negedge clk);
        chk(wr_cnt == 0, "R1 no writes after reset", wr_cnt, 0);
        chk(done_cnt == 0, "R1 no done after reset", done_cnt, 0);
    endtask

    task automatic test_busy_start_r10();
        clear_log();
        pulse_start(0, 1'b1, 12'h00E);
        repeat (6) @(negedge clk);
        pulse_start(3, 1'b0, 12'hFFF);
        bw_mode_i = 2'b10; hi_ack_i = 1'b0; short_cap_i = 12'h0F0;
        wait_done();
        verify(0, 1'b1, 12'h00E, "R10 config held");
        clear_log();
        repeat (40) @(negedge clk);
        chk(wr_cnt == 0, "R10 ignored start left no pass", wr_cnt, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset_r1();
        run_pass(0, 1'b1, 12'h000, "R2 R4 high ack standard");
        run_pass(0, 1'b0, 12'h000, "R3 R4 base ack standard");
        run_pass(2, 1'b1, 12'h00E, "R5 half mode");
        run_pass(3, 1'b1, 12'hFFF, "R5 quarter mode");
        run_pass(3, 1'b0, 12'h00E, "R5 R3 quarter base");
        run_pass(1, 1'b1, 12'h00E, "R6 turbo mode");
        run_pass(1, 1'b0, 12'h801, "R6 R11 turbo base");
        test_busy_start_r10();
        summary();
    end

endmodule